// File: doc/BRIEF.md
# Multi-Mode Down-Counting Timer with Capture

The block is a down-counting timer built around one counter and two reload/capture registers, called the A register and the B register. It has two pins, pin A and pin B. A 3-bit mode code selects one of three behaviours.

In pulse-width mode, the counter counts instruction-clock ticks. When it underflows, it reloads from the A register and the B register in turn. Pin A can optionally toggle on each reload, which gives a two-phase waveform. In event-counter mode, each rising edge on pin A decrements the counter. In capture mode, the counter runs on ticks, and selected edges on pin A or pin B copy the current count into the A register or the B register.

The mode code also decides what raises each of the two sticky interrupt-pending flags. Software clears a flag by pulsing a clear strobe.

Top module: `cap_pwm_timer`

## Requirements
- R1: The mode code selects the function. 3'b100 and 3'b101 select pulse-width mode, 3'b000 and 3'b001 select event-counter mode, and 3'b010, 3'b110, 3'b011 and 3'b111 select capture mode. Pulse-width and capture modes count on `tick_i`. Event-counter mode counts rising edges of pin A and ignores `tick_i`.
- R2: While `run_i` is high, each count event lowers the counter by one. While `run_i` is low, the counter holds, no flag is set, and pin edges and ticks are ignored.
- R3: In event-counter and capture modes, a count event at 0x0000 wraps the counter to 0xFFFF and sets flag A.
- R4: In pulse-width mode, a count event at 0x0000 loads the counter instead of wrapping. The loads alternate between the A register and the B register, and the first load after reset comes from the A register. A load from A sets flag A. A load from B sets flag B.
- R5: In code 3'b101 only, `pin_a_o` toggles on every pulse-width reload and `pin_a_oe_o` is 1. In every other code, `pin_a_oe_o` is 0 and `pin_a_o` keeps its level.
- R6: In capture mode, the selected edge of pin A copies the counter into the A register and sets flag A. The selected edge of pin B copies the counter into the B register and sets flag B. The selected edges are:
  - code 3'b010: pin A rising, pin B rising;
  - code 3'b110: pin A rising, pin B falling;
  - codes 3'b011 and 3'b111: pin A falling, pin B falling.
- R7: In event-counter mode, a rising edge on pin B sets flag B.
- R8: Each pin passes through a two-flop synchronizer and an edge detector. A pin change applied before clock edge k takes effect at edge k+2 and has no effect at edge k+1.
- R9: The flags stay set until cleared by a one-cycle strobe on `irq_a_clr_i` or `irq_b_clr_i`. If a set event and a clear arrive in the same cycle, the set wins.
- R10: A write to the counter, the A register or the B register takes effect at the next edge. It overrides any hardware update of that register in the same cycle. A counter write also suppresses that cycle's underflow and its flag. A capture that coincides with a register write still sets its flag.
- R11: After reset, the counter, the A register, the B register, both flags and `pin_a_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle instruction-clock enable |
| pin_a_i | input | 1 | Pin A level (asynchronous) |
| pin_b_i | input | 1 | Pin B level (asynchronous) |
| run_i | input | 1 | Run enable |
| mode_i | input | 3 | Mode code |
| cnt_wr_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 16 | Counter write data |
| ra_wr_i | input | 1 | A register write strobe |
| ra_wdata_i | input | 16 | A register write data |
| rb_wr_i | input | 1 | B register write strobe |
| rb_wdata_i | input | 16 | B register write data |
| irq_a_clr_i | input | 1 | Flag A clear strobe |
| irq_b_clr_i | input | 1 | Flag B clear strobe |
| pin_a_o | output | 1 | Pin A drive level |
| pin_a_oe_o | output | 1 | Pin A output enable |
| irq_a_o | output | 1 | Flag A pending |
| irq_b_o | output | 1 | Flag B pending |
| cnt_o | output | 16 | Counter readback |
| ra_o | output | 16 | A register readback |
| rb_o | output | 16 | B register readback |

## Verification
Register writes and tick-driven counting show their effect one edge after the inputs are applied. The bench therefore drives on the falling edge and reads at the next falling edge.

Pin-driven results are due at the third edge after the pin changes. The bench reads once after two edges to confirm that nothing has moved yet, then again after the third.

The pulse-width sweep covers every pair of reload values from 0 to 3 in both pulse-width codes. It steps a tick-by-tick arithmetic model in lockstep with the design and compares the counter, the flags and the pin on every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    FN_EVT = 2'd0,
    FN_PWM = 2'd1,
    FN_CAP = 2'd2
  } tmr_fn_e;

  typedef struct packed {
    tmr_fn_e fn;
    logic    a_toggle;
    logic    a_fall;
    logic    b_fall;
  } tmr_mode_t;

endpackage

// File: rtl/tmr_mode_dec.sv
module tmr_mode_dec
  import tmr_pkg::*;
(
  input  logic [2:0] mode_i,
  output tmr_mode_t  dec_o
);

  always_comb begin
    dec_o.fn       = FN_EVT;
    dec_o.a_toggle = 1'b0;
    dec_o.a_fall   = 1'b0;
    dec_o.b_fall   = 1'b0;
    unique case (mode_i)
      3'b100: dec_o.fn = FN_PWM;
      3'b101: begin
        dec_o.fn       = FN_PWM;
        dec_o.a_toggle = 1'b1;
      end
      3'b000, 3'b001: dec_o.fn = FN_EVT;
      3'b010: dec_o.fn = FN_CAP;
      3'b110: begin
        dec_o.fn     = FN_CAP;
        dec_o.b_fall = 1'b1;
      end
      default: begin // 011, 111
        dec_o.fn     = FN_CAP;
        dec_o.a_fall = 1'b1;
        dec_o.b_fall = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];

  p_single_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  p_single_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
  p_edge_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_o, fall_o}));

endmodule

// File: rtl/tmr_irq_flag.sv
module tmr_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  p_w1c_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> !q_o);
  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o && !clr_i |=> q_o);

endmodule

// File: rtl/cap_pwm_timer.sv
module cap_pwm_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             pin_a_i,
  input  logic             pin_b_i,
  input  logic             run_i,
  input  logic [2:0]       mode_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             ra_wr_i,
  input  logic [CNT_W-1:0] ra_wdata_i,
  input  logic             rb_wr_i,
  input  logic [CNT_W-1:0] rb_wdata_i,
  input  logic             irq_a_clr_i,
  input  logic             irq_b_clr_i,
  output logic             pin_a_o,
  output logic             pin_a_oe_o,
  output logic             irq_a_o,
  output logic             irq_b_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] ra_o,
  output logic [CNT_W-1:0] rb_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  tmr_mode_t dec;
  logic a_rise, a_fall, b_rise, b_fall;
  logic is_pwm, is_evt, is_cap;
  logic a_sel, b_sel;
  logic cnt_ev, at_zero, wrap;
  logic reload_a, reload_b, cap_a, cap_b;
  logic set_a, set_b;
  logic [CNT_W-1:0] cnt_q, ra_q, rb_q;
  logic ph_q, pin_a_q;

  tmr_mode_dec u_dec (
    .mode_i (mode_i),
    .dec_o  (dec)
  );

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_a_i),
    .rise_o (a_rise),
    .fall_o (a_fall)
  );

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_b_i),
    .rise_o (b_rise),
    .fall_o (b_fall)
  );

  assign is_pwm = (dec.fn == FN_PWM);
  assign is_evt = (dec.fn == FN_EVT);
  assign is_cap = (dec.fn == FN_CAP);

  assign a_sel = dec.a_fall ? a_fall : a_rise;
  assign b_sel = dec.b_fall ? b_fall : b_rise;

  assign cnt_ev   = run_i & (is_evt ? a_rise : tick_i);
  assign at_zero  = (cnt_q == '0);
  assign wrap     = cnt_ev & at_zero & ~cnt_wr_i;
  assign reload_a = is_pwm & wrap & ~ph_q;
  assign reload_b = is_pwm & wrap & ph_q;
  assign cap_a    = run_i & is_cap & a_sel;
  assign cap_b    = run_i & is_cap & b_sel;

  assign set_a = reload_a | (~is_pwm & wrap) | cap_a;
  assign set_b = reload_b | (run_i & is_evt & b_rise) | cap_b;

  // counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_wr_i) begin
      cnt_q <= cnt_wdata_i;
    end else if (cnt_ev) begin
      if (is_pwm && at_zero) cnt_q <= ph_q ? rb_q : ra_q;
      else                   cnt_q <= cnt_q - 1'b1;
    end
  end

  // reload / capture registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ra_q <= '0;
      rb_q <= '0;
    end else begin
      if (ra_wr_i)    ra_q <= ra_wdata_i;
      else if (cap_a) ra_q <= cnt_q;
      if (rb_wr_i)    rb_q <= rb_wdata_i;
      else if (cap_b) rb_q <= cnt_q;
    end
  end

  // reload phase and pin A toggle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= 1'b0;
      pin_a_q <= 1'b0;
    end else if (is_pwm && wrap) begin
      ph_q <= ~ph_q;
      if (dec.a_toggle) pin_a_q <= ~pin_a_q;
    end
  end

  tmr_irq_flag u_flag_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_a),
    .clr_i  (irq_a_clr_i),
    .q_o    (irq_a_o)
  );

  tmr_irq_flag u_flag_b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_b),
    .clr_i  (irq_b_clr_i),
    .q_o    (irq_b_o)
  );

  assign pin_a_o    = pin_a_q;
  assign pin_a_oe_o = is_pwm & dec.a_toggle;
  assign cnt_o      = cnt_q;
  assign ra_o       = ra_q;
  assign rb_o       = rb_q;

  p_hold_stopped_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !cnt_wr_i |=> $stable(cnt_q));
  p_no_flag_stopped_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !irq_a_o && !irq_b_o |=> !irq_a_o && !irq_b_o);
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_pwm && wrap |=> cnt_q == CNT_MAX && irq_a_o);
  p_reload_a_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_a |=> cnt_q == $past(ra_q) && irq_a_o);
  p_reload_b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_b |=> cnt_q == $past(rb_q) && irq_b_o);
  p_pin_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_a_oe_o |=> $stable(pin_a_o));
  p_cap_a_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_a && !ra_wr_i |=> ra_q == $past(cnt_q) && irq_a_o);
  p_cap_b_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_b && !rb_wr_i |=> rb_q == $past(cnt_q) && irq_b_o);
  p_wr_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> cnt_q == $past(cnt_wdata_i));

endmodule

// File: tb/cap_pwm_timer_tb.sv
module cap_pwm_timer_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0, pin_a_i = 1'b0, pin_b_i = 1'b0, run_i = 1'b0;
  logic [2:0]  mode_i = 3'b000;
  logic        cnt_wr_i = 1'b0, ra_wr_i = 1'b0, rb_wr_i = 1'b0;
  logic [15:0] cnt_wdata_i = '0, ra_wdata_i = '0, rb_wdata_i = '0;
  logic        irq_a_clr_i = 1'b0, irq_b_clr_i = 1'b0;
  logic        pin_a_o, pin_a_oe_o, irq_a_o, irq_b_o;
  logic [15:0] cnt_o, ra_o, rb_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cap_pwm_timer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .pin_a_i(pin_a_i), .pin_b_i(pin_b_i), .run_i(run_i), .mode_i(mode_i),
    .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i),
    .ra_wr_i(ra_wr_i), .ra_wdata_i(ra_wdata_i),
    .rb_wr_i(rb_wr_i), .rb_wdata_i(rb_wdata_i),
    .irq_a_clr_i(irq_a_clr_i), .irq_b_clr_i(irq_b_clr_i),
    .pin_a_o(pin_a_o), .pin_a_oe_o(pin_a_oe_o),
    .irq_a_o(irq_a_o), .irq_b_o(irq_b_o),
    .cnt_o(cnt_o), .ra_o(ra_o), .rb_o(rb_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write counter/registers and clear flags in one cycle with tick low
  task automatic setup(input logic [15:0] c, input logic [15:0] a, input logic [15:0] b);
    tick_i = 1'b0;
    cnt_wr_i = 1'b1; cnt_wdata_i = c;
    ra_wr_i = 1'b1;  ra_wdata_i = a;
    rb_wr_i = 1'b1;  rb_wdata_i = b;
    irq_a_clr_i = 1'b1; irq_b_clr_i = 1'b1;
    step(1);
    cnt_wr_i = 1'b0; ra_wr_i = 1'b0; rb_wr_i = 1'b0;
    irq_a_clr_i = 1'b0; irq_b_clr_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] exp_cnt;
    logic        exp_ph, exp_pin, exp_ia, exp_ib;
    logic [2:0]  cap_modes [4];
    cap_modes[0] = 3'b010; cap_modes[1] = 3'b110;
    cap_modes[2] = 3'b011; cap_modes[3] = 3'b111;

    step(2);
    // R11 reset state
    check("R11 cnt", cnt_o, 0);
    check("R11 ra", ra_o, 0);
    check("R11 rb", rb_o, 0);
    check("R11 irq_a", irq_a_o, 0);
    check("R11 irq_b", irq_b_o, 0);
    check("R11 pin_a", pin_a_o, 0);
    rst_ni = 1'b1;
    step(1);

    // R10 writes land next edge
    setup(16'h0005, 16'h0003, 16'h0007);
    check("R10 cnt write", cnt_o, 16'h0005);
    check("R10 ra write", ra_o, 16'h0003);
    check("R10 rb write", rb_o, 16'h0007);

    // R1 R2 capture mode counts ticks, one per tick
    mode_i = 3'b010; run_i = 1'b1;
    setup(16'h0040, 0, 0);
    exp_cnt = 16'h0040;
    for (int i = 0; i < 10; i++) begin
      tick_i = (i % 2 == 0);
      if (tick_i) exp_cnt = exp_cnt - 1;
      step(1);
      check("R2 tick count", cnt_o, exp_cnt);
    end
    check("R5 oe low in capture", pin_a_oe_o, 0);

    // R2 run low: hold, ignore ticks and edges
    run_i = 1'b0; tick_i = 1'b1; mode_i = 3'b000;
    pin_a_i = 1'b1; pin_b_i = 1'b1;
    step(3);
    pin_a_i = 1'b0; pin_b_i = 1'b0;
    step(3);
    check("R2 hold when stopped", cnt_o, exp_cnt);
    check("R2 no irq_a when stopped", irq_a_o, 0);
    check("R2 no irq_b when stopped", irq_b_o, 0);

    // R3 capture-mode underflow wraps
    mode_i = 3'b010; run_i = 1'b1;
    setup(16'h0001, 0, 0);
    tick_i = 1'b1;
    step(1);
    check("R3 before wrap irq_a", irq_a_o, 0);
    step(1);
    tick_i = 1'b0;
    check("R3 wrap value", cnt_o, 16'hFFFF);
    check("R3 wrap irq_a", irq_a_o, 1);
    irq_a_clr_i = 1'b1; step(1); irq_a_clr_i = 1'b0;
    check("R9 w1c", irq_a_o, 0);

    // R9 set beats clear in same cycle
    setup(16'h0000, 0, 0);
    tick_i = 1'b1; irq_a_clr_i = 1'b1;
    step(1);
    tick_i = 1'b0; irq_a_clr_i = 1'b0;
    check("R9 set wins", irq_a_o, 1);
    step(2);
    check("R9 sticky", irq_a_o, 1);

    // R10 counter write beats underflow
    setup(16'h0000, 0, 0);
    tick_i = 1'b1; cnt_wr_i = 1'b1; cnt_wdata_i = 16'h0055;
    step(1);
    tick_i = 1'b0; cnt_wr_i = 1'b0;
    check("R10 write over wrap", cnt_o, 16'h0055);
    check("R10 no irq on suppressed wrap", irq_a_o, 0);

    // R1 R3 R7 R8 event counter: rising pin A edges, ticks ignored
    setup(16'h0002, 0, 0);
    exp_cnt = 16'h0002;
    tick_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      mode_i = (k < 2) ? 3'b000 : 3'b001;
      pin_a_i = 1'b1;
      step(2);
      check("R8 no effect at second edge", cnt_o, exp_cnt);
      step(1);
      exp_cnt = exp_cnt - 1;
      check("R1 event count", cnt_o, exp_cnt);
      check("R3 event irq_a", irq_a_o, (k >= 2));
      pin_a_i = 1'b0;
      step(3);
      check("R1 falling edge ignored", cnt_o, exp_cnt);
    end
    tick_i = 1'b0;
    pin_b_i = 1'b1;
    step(3);
    check("R7 pin B rise irq_b", irq_b_o, 1);
    irq_b_clr_i = 1'b1; pin_b_i = 1'b0;
    step(1);
    irq_b_clr_i = 1'b0;
    step(3);
    check("R7 pin B fall no irq_b", irq_b_o, 0);

    // R6 capture edge selection, each mode, pin and direction
    foreach (cap_modes[m]) begin
      mode_i = cap_modes[m];
      for (int p = 0; p < 2; p++) begin
        for (int d = 0; d < 2; d++) begin
          logic fall_sel, sel;
          logic [15:0] v;
          v = 16'h1000 + 16'(m * 16 + p * 4 + d);
          fall_sel = (p == 0) ? (m >= 2) : (m >= 1);
          sel = (d == 1) ? fall_sel : !fall_sel;
          setup(v, 16'h0000, 16'h0000);
          if (p == 0) pin_a_i = (d == 0);
          else        pin_b_i = (d == 0);
          step(3);
          if (p == 0) begin
            check("R6 ra capture", ra_o, sel ? v : 16'h0);
            check("R6 irq_a capture", irq_a_o, sel);
          end else begin
            check("R6 rb capture", rb_o, sel ? v : 16'h0);
            check("R6 irq_b capture", irq_b_o, sel);
          end
        end
      end
    end

    // R10 register write beats same-cycle capture, flag still set
    mode_i = 3'b010;
    setup(16'h0777, 16'h0000, 16'h0000);
    pin_a_i = 1'b1;
    step(2);
    ra_wr_i = 1'b1; ra_wdata_i = 16'hBEEF;
    step(1);
    ra_wr_i = 1'b0;
    check("R10 ra write over capture", ra_o, 16'hBEEF);
    check("R10 capture irq_a kept", irq_a_o, 1);
    pin_a_i = 1'b0;
    step(3);

    // R4 R5 pulse-width sweep over reload pairs, both codes
    exp_ph = 1'b0; exp_pin = 1'b0;
    for (int md = 0; md < 2; md++) begin
      mode_i = (md == 0) ? 3'b100 : 3'b101;
      for (int a = 0; a < 4; a++) begin
        for (int b = 0; b < 4; b++) begin
          setup(16'h0000, 16'(a), 16'(b));
          exp_cnt = 0; exp_ia = 0; exp_ib = 0;
          check("R5 oe", pin_a_oe_o, (md == 1));
          for (int j = 0; j < 12; j++) begin
            tick_i = (j % 3 != 2);
            if (tick_i) begin
              if (exp_cnt == 0) begin
                if (!exp_ph) begin exp_cnt = 16'(a); exp_ia = 1; end
                else         begin exp_cnt = 16'(b); exp_ib = 1; end
                exp_ph = !exp_ph;
                if (md == 1) exp_pin = !exp_pin;
              end else begin
                exp_cnt = exp_cnt - 1;
              end
            end
            step(1);
            check("R4 pwm count", cnt_o, exp_cnt);
            check("R4 pwm irq_a", irq_a_o, exp_ia);
            check("R4 pwm irq_b", irq_b_o, exp_ib);
            check("R5 pin level", pin_a_o, exp_pin);
          end
        end
      end
    end
    tick_i = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule